// File: doc/BRIEF.md
# ASID-Tagged Translation Lookaside Buffer

This block is a small, fully associative cache of address translations. Each slot pairs a virtual page number with a physical frame number and a set of protection bits. Each slot is also tagged with an address-space identifier (ASID), so translations from several processes can live side by side. A lookup presents a page number and the current ASID. In the same cycle the block answers with a hit flag, the frame and the protection bits, without any memory access. When the lookup misses, the block only reports the miss. The page-table walk happens elsewhere, and its result comes back through the fill port.

A fill goes to the slot that already holds the same page and ASID if there is one. Otherwise it goes to the lowest-numbered empty slot. Otherwise it replaces the least recently used slot that is not pinned. A slot is pinned (wired) by setting the wired flag on the fill that installs it. A later fill of the same page and ASID overwrites the slot together with its wired flag, which is the way a slot is released. Wired slots survive a flush. The flush clears every other slot in one cycle, so entries from an earlier address space cannot produce a hit. Recency is kept as a per-slot age counter. A hit or a fill makes that slot the most recent.

Top module: `asid_tlb`

## Requirements
- R1: A lookup with `lk_valid` high hits when a valid slot holds a page number equal to `lk_vpn` and an ASID equal to `lk_asid`. `lk_hit`, `lk_pfn` and `lk_prot` reflect that slot combinationally, in the same cycle.
- R2: A slot whose page number matches but whose ASID differs from `lk_asid` does not produce a hit.
- R3: On a miss, `lk_hit` is 0 and `lk_pfn` and `lk_prot` are all zeros.
- R4: A fill that matches no slot writes the lowest-indexed invalid slot. Lookups see the new translation from the next cycle on.
- R5: A fill whose page number and ASID equal those of a valid slot overwrites that slot, including its wired flag. At most one slot ever matches a lookup key.
- R6: When no slot is free, a fill replaces the non-wired slot that was least recently hit or filled. A hit or a fill makes its slot the most recently used.
- R7: A wired slot is never chosen as a replacement victim.
- R8: `flush` invalidates every non-wired slot at the next clock edge. Wired slots stay valid.
- R9: A fill that matches no slot is ignored when every slot is valid and wired.
- R10: When `flush` and a fill occur in the same cycle, the flush is applied first, and the filled translation remains valid afterwards.
- R11: After reset every slot is invalid, so every lookup misses.
- R12: With `lk_valid` low, `lk_hit` is 0 and `lk_pfn` and `lk_prot` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 20 | Lookup virtual page number |
| lk_asid | input | 8 | Current address-space identifier |
| lk_hit | output | 1 | Lookup hit |
| lk_pfn | output | 20 | Frame number on hit, else zero |
| lk_prot | output | 3 | Protection bits on hit, else zero |
| fill_valid | input | 1 | Install a translation |
| fill_vpn | input | 20 | Page number to install |
| fill_asid | input | 8 | ASID to install |
| fill_pfn | input | 20 | Frame number to install |
| fill_prot | input | 3 | Protection bits to install |
| fill_wired | input | 1 | Pin the installed slot against replacement and flush |
| flush | input | 1 | Invalidate all non-wired slots |

## Verification
A flush and a fill can land on the same clock edge. The ordering rule decides whether the new translation survives. The bench installs one non-wired page, then drives `flush` together with a fill of a second page in a single cycle. It judges the result by lookups afterwards: the older page must miss and the freshly filled page must hit with its frame. A lookup hit and a fill also update the recency order in the same step. This is judged through which slot the next replacement evicts.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    typedef enum logic [1:0] {
        FILL_NONE   = 2'd0,
        FILL_MATCH  = 2'd1,
        FILL_FREE   = 2'd2,
        FILL_VICTIM = 2'd3
    } fill_src_e;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int ASID_W  = 8
) (
    input  logic [ENTRIES-1:0]        valid,
    input  logic [ENTRIES*VPN_W-1:0]  vpn_flat,
    input  logic [ENTRIES*ASID_W-1:0] asid_flat,
    input  logic [VPN_W-1:0]          key_vpn,
    input  logic [ASID_W-1:0]         key_asid,
    output logic [ENTRIES-1:0]        hit_vec
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = valid[g]
                          && (vpn_flat[g*VPN_W +: VPN_W] == key_vpn)
                          && (asid_flat[g*ASID_W +: ASID_W] == key_asid);
    end
endmodule

// File: rtl/tlb_first.sv
module tlb_first #(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] req,
    output logic               found,
    output logic [IDX_W-1:0]   idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES*IDX_W-1:0] age_flat,
    input  logic [ENTRIES-1:0]       eligible,
    input  logic                     touch_a_en,
    input  logic [IDX_W-1:0]         touch_a_idx,
    input  logic                     touch_b_en,
    input  logic [IDX_W-1:0]         touch_b_idx,
    output logic [ENTRIES*IDX_W-1:0] age_next_flat,
    output logic                     victim_found,
    output logic [IDX_W-1:0]         victim_idx
);
    logic [IDX_W-1:0] age_cur [ENTRIES];
    logic [IDX_W-1:0] age_mid [ENTRIES];
    logic [IDX_W-1:0] age_fin [ENTRIES];
    logic [IDX_W-1:0] ref_a;
    logic [IDX_W-1:0] ref_b;
    logic [IDX_W-1:0] best_age;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_unpack
        assign age_cur[g] = age_flat[g*IDX_W +: IDX_W];
        assign age_next_flat[g*IDX_W +: IDX_W] = age_fin[g];
    end

    // Ages form a permutation: a touched slot goes to 0 and every
    // younger slot moves one step older. Touch b is applied after touch a.
    always_comb begin
        ref_a = age_cur[touch_a_idx];
        for (int i = 0; i < ENTRIES; i++) begin
            age_mid[i] = age_cur[i];
            if (touch_a_en) begin
                if (IDX_W'(i) == touch_a_idx)
                    age_mid[i] = '0;
                else if (age_cur[i] < ref_a)
                    age_mid[i] = age_cur[i] + 1'b1;
            end
        end
        ref_b = age_mid[touch_b_idx];
        for (int i = 0; i < ENTRIES; i++) begin
            age_fin[i] = age_mid[i];
            if (touch_b_en) begin
                if (IDX_W'(i) == touch_b_idx)
                    age_fin[i] = '0;
                else if (age_mid[i] < ref_b)
                    age_fin[i] = age_mid[i] + 1'b1;
            end
        end
    end

    // Victim: oldest eligible slot, judged on the current ages.
    always_comb begin
        victim_found = 1'b0;
        victim_idx   = '0;
        best_age     = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (eligible[i] && (!victim_found || age_cur[i] > best_age)) begin
                victim_found = 1'b1;
                victim_idx   = IDX_W'(i);
                best_age     = age_cur[i];
            end
        end
    end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20,
    parameter int ASID_W  = 8,
    parameter int PROT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              lk_hit,
    output logic [PFN_W-1:0]  lk_pfn,
    output logic [PROT_W-1:0] lk_prot,
    input  logic              fill_valid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic [PROT_W-1:0] fill_prot,
    input  logic              fill_wired,
    input  logic              flush
);
    import tlb_pkg::*;

    localparam int IDX_W = $clog2(ENTRIES);

    typedef struct {
        logic [ENTRIES-1:0] valid;
        logic [ENTRIES-1:0] wired;
        logic [VPN_W-1:0]   vpn  [ENTRIES];
        logic [ASID_W-1:0]  asid [ENTRIES];
        logic [PFN_W-1:0]   pfn  [ENTRIES];
        logic [PROT_W-1:0]  prot [ENTRIES];
        logic [IDX_W-1:0]   age  [ENTRIES];
    } tlb_state_t;

    tlb_state_t st_q, st_d;

    logic [ENTRIES*VPN_W-1:0]  vpn_flat;
    logic [ENTRIES*ASID_W-1:0] asid_flat;
    logic [ENTRIES*IDX_W-1:0]  age_flat;
    logic [ENTRIES*IDX_W-1:0]  age_next_flat;
    logic [ENTRIES-1:0]        lk_match;
    logic [ENTRIES-1:0]        fill_match;
    logic [ENTRIES-1:0]        valid_vec;
    logic [ENTRIES-1:0]        wired_vec;
    logic                      lk_any;
    logic [IDX_W-1:0]          lk_idx;
    logic                      fill_hit_any;
    logic [IDX_W-1:0]          fill_hit_idx;
    logic                      free_found;
    logic [IDX_W-1:0]          free_idx;
    logic                      victim_found;
    logic [IDX_W-1:0]          victim_idx;
    fill_src_e                 fill_src;
    logic [IDX_W-1:0]          fill_idx;
    logic                      fill_go;
    logic                      hit_touch;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_flat
        assign vpn_flat[g*VPN_W +: VPN_W]    = st_q.vpn[g];
        assign asid_flat[g*ASID_W +: ASID_W] = st_q.asid[g];
        assign age_flat[g*IDX_W +: IDX_W]    = st_q.age[g];
    end

    assign valid_vec = st_q.valid;
    assign wired_vec = st_q.wired;

    tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lk_cam (
        .valid(st_q.valid), .vpn_flat(vpn_flat), .asid_flat(asid_flat),
        .key_vpn(lk_vpn), .key_asid(lk_asid), .hit_vec(lk_match)
    );

    tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_fill_cam (
        .valid(st_q.valid), .vpn_flat(vpn_flat), .asid_flat(asid_flat),
        .key_vpn(fill_vpn), .key_asid(fill_asid), .hit_vec(fill_match)
    );

    tlb_first #(.ENTRIES(ENTRIES)) u_lk_enc (
        .req(lk_match), .found(lk_any), .idx(lk_idx)
    );

    tlb_first #(.ENTRIES(ENTRIES)) u_fill_enc (
        .req(fill_match), .found(fill_hit_any), .idx(fill_hit_idx)
    );

    tlb_first #(.ENTRIES(ENTRIES)) u_free_enc (
        .req(~st_q.valid), .found(free_found), .idx(free_idx)
    );

    tlb_lru #(.ENTRIES(ENTRIES)) u_lru (
        .age_flat(age_flat),
        .eligible(st_q.valid & ~st_q.wired),
        .touch_a_en(hit_touch),
        .touch_a_idx(lk_idx),
        .touch_b_en(fill_go),
        .touch_b_idx(fill_idx),
        .age_next_flat(age_next_flat),
        .victim_found(victim_found),
        .victim_idx(victim_idx)
    );

    // Lookup answer, same cycle
    assign hit_touch = lk_valid && lk_any;
    assign lk_hit    = hit_touch;
    assign lk_pfn    = hit_touch ? st_q.pfn[lk_idx]  : '0;
    assign lk_prot   = hit_touch ? st_q.prot[lk_idx] : '0;

    // Fill target: existing key, then free slot, then LRU non-wired
    always_comb begin
        fill_src = FILL_NONE;
        fill_idx = '0;
        if (fill_hit_any) begin
            fill_src = FILL_MATCH;
            fill_idx = fill_hit_idx;
        end else if (free_found) begin
            fill_src = FILL_FREE;
            fill_idx = free_idx;
        end else if (victim_found) begin
            fill_src = FILL_VICTIM;
            fill_idx = victim_idx;
        end
    end

    assign fill_go = fill_valid && (fill_src != FILL_NONE);

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < ENTRIES; i++) begin
            st_d.age[i] = age_next_flat[i*IDX_W +: IDX_W];
        end
        if (flush) begin
            st_d.valid = st_q.valid & st_q.wired;
        end
        if (fill_go) begin
            st_d.valid[fill_idx] = 1'b1;
            st_d.wired[fill_idx] = fill_wired;
            st_d.vpn[fill_idx]   = fill_vpn;
            st_d.asid[fill_idx]  = fill_asid;
            st_d.pfn[fill_idx]   = fill_pfn;
            st_d.prot[fill_idx]  = fill_prot;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.valid <= '0;
            st_q.wired <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                st_q.vpn[i]  <= '0;
                st_q.asid[i] <= '0;
                st_q.pfn[i]  <= '0;
                st_q.prot[i] <= '0;
                st_q.age[i]  <= IDX_W'(i);
            end
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/tlb_checker.sv
module tlb_checker #(
    parameter int ENTRIES = 16,
    parameter int PFN_W   = 20,
    parameter int PROT_W  = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lk_valid,
    input logic               lk_hit,
    input logic [PFN_W-1:0]   lk_pfn,
    input logic [PROT_W-1:0]  lk_prot,
    input logic [ENTRIES-1:0] lk_match,
    input logic [ENTRIES-1:0] valid_q,
    input logic [ENTRIES-1:0] wired_q,
    input logic               flush,
    input logic               fill_valid
);
    assert_single_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));

    assert_idle_no_hit_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> !lk_hit);

    assert_miss_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_pfn == '0) && (lk_prot == '0));

    assert_wired_is_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wired_q & ~valid_q) == '0);

    assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush && !fill_valid |=> (valid_q & ~wired_q) == '0);

    assert_flush_keeps_wired_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush && !fill_valid |=> valid_q == $past(valid_q & wired_q));

    assert_all_wired_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid && !flush && (&wired_q) |=> valid_q == $past(valid_q));

    assert_reset_empty_R11: assert property (@(posedge clk)
        !rst_n |=> valid_q == '0);
endmodule

bind asid_tlb tlb_checker #(.ENTRIES(ENTRIES), .PFN_W(PFN_W), .PROT_W(PROT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_hit(lk_hit),
    .lk_pfn(lk_pfn), .lk_prot(lk_prot), .lk_match(lk_match),
    .valid_q(valid_vec), .wired_q(wired_vec), .flush(flush),
    .fill_valid(fill_valid)
);

// File: tb/test_asid_tlb.sv
`timescale 1ns/1ps
module test_asid_tlb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [19:0] lk_vpn = '0;
    logic [7:0]  lk_asid = '0;
    logic        lk_hit;
    logic [19:0] lk_pfn;
    logic [2:0]  lk_prot;
    logic        fill_valid = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [7:0]  fill_asid = '0;
    logic [19:0] fill_pfn = '0;
    logic [2:0]  fill_prot = '0;
    logic        fill_wired = 1'b0;
    logic        flush = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    asid_tlb i_asid_tlb (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
        .lk_hit(lk_hit), .lk_pfn(lk_pfn), .lk_prot(lk_prot),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
        .fill_pfn(fill_pfn), .fill_prot(fill_prot), .fill_wired(fill_wired),
        .flush(flush)
    );

    localparam logic [1:0] OP_LOOK  = 2'd0;
    localparam logic [1:0] OP_FILL  = 2'd1;
    localparam logic [1:0] OP_FLUSH = 2'd2;

    typedef struct packed {
        logic [1:0]  op;
        logic [19:0] vpn;
        logic [7:0]  asid;
        logic [19:0] pfn;
        logic [2:0]  prot;
        logic        hit;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{OP_LOOK,  20'h00100, 8'd1, 20'h00000, 3'd0, 1'b0},
        '{OP_FILL,  20'h00100, 8'd1, 20'hAAAAA, 3'd5, 1'b0},
        '{OP_LOOK,  20'h00100, 8'd1, 20'hAAAAA, 3'd5, 1'b1},
        '{OP_LOOK,  20'h00100, 8'd2, 20'h00000, 3'd0, 1'b0},
        '{OP_LOOK,  20'h00101, 8'd1, 20'h00000, 3'd0, 1'b0},
        '{OP_FILL,  20'h00100, 8'd2, 20'h22222, 3'd3, 1'b0},
        '{OP_LOOK,  20'h00100, 8'd2, 20'h22222, 3'd3, 1'b1},
        '{OP_LOOK,  20'h00100, 8'd1, 20'hAAAAA, 3'd5, 1'b1},
        '{OP_FILL,  20'h00100, 8'd1, 20'h33333, 3'd1, 1'b0},
        '{OP_LOOK,  20'h00100, 8'd1, 20'h33333, 3'd1, 1'b1},
        '{OP_FLUSH, 20'h00000, 8'd0, 20'h00000, 3'd0, 1'b0},
        '{OP_LOOK,  20'h00100, 8'd1, 20'h00000, 3'd0, 1'b0},
        '{OP_LOOK,  20'h00100, 8'd2, 20'h00000, 3'd0, 1'b0}
    };
    localparam string TAGS [NV] = '{
        "R11", "R4", "R1", "R2", "R3", "R4", "R1",
        "R2", "R5", "R5", "R8", "R8", "R8"
    };

    task automatic drive_idle();
        lk_valid = 1'b0; fill_valid = 1'b0; flush = 1'b0; fill_wired = 1'b0;
    endtask

    task automatic look(input logic [19:0] vpn, input logic [7:0] asid,
                        input logic hit, input logic [19:0] pfn,
                        input logic [2:0] prot, input string tag);
        @(negedge clk);
        drive_idle();
        lk_valid = 1'b1; lk_vpn = vpn; lk_asid = asid;
        #1;
        checks++;
        if (lk_hit !== hit || lk_pfn !== pfn || lk_prot !== prot) begin
            errors++;
            $display("FAIL %s vpn=%h asid=%0d: got hit=%b pfn=%h prot=%0d, expected hit=%b pfn=%h prot=%0d",
                     tag, vpn, asid, lk_hit, lk_pfn, lk_prot, hit, pfn, prot);
        end
    endtask

    task automatic fill(input logic [19:0] vpn, input logic [7:0] asid,
                        input logic [19:0] pfn, input logic [2:0] prot,
                        input logic wired, input logic with_flush);
        @(negedge clk);
        drive_idle();
        fill_valid = 1'b1; fill_vpn = vpn; fill_asid = asid;
        fill_pfn = pfn; fill_prot = prot; fill_wired = wired;
        flush = with_flush;
    endtask

    task automatic do_flush();
        @(negedge clk);
        drive_idle();
        flush = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk
        for (int k = 0; k < NV; k++) begin
            case (VECS[k].op)
                OP_FILL:  fill(VECS[k].vpn, VECS[k].asid, VECS[k].pfn, VECS[k].prot, 1'b0, 1'b0);
                OP_FLUSH: do_flush();
                default:  look(VECS[k].vpn, VECS[k].asid, VECS[k].hit,
                               VECS[k].pfn, VECS[k].prot, TAGS[k]);
            endcase
        end

        // R6: LRU replacement, hits refresh recency
        for (int i = 0; i < 16; i++)
            fill(20'(i), 8'd1, 20'h01000 + 20'(i), 3'd2, 1'b0, 1'b0);
        look(20'd0, 8'd1, 1'b1, 20'h01000, 3'd2, "R6");
        fill(20'h00020, 8'd1, 20'h05020, 3'd4, 1'b0, 1'b0);
        look(20'd1, 8'd1, 1'b0, 20'h0, 3'd0, "R6");
        look(20'd0, 8'd1, 1'b1, 20'h01000, 3'd2, "R6");
        look(20'h00020, 8'd1, 1'b1, 20'h05020, 3'd4, "R6");
        look(20'd2, 8'd1, 1'b1, 20'h01002, 3'd2, "R6");
        fill(20'h00021, 8'd1, 20'h05021, 3'd4, 1'b0, 1'b0);
        look(20'd3, 8'd1, 1'b0, 20'h0, 3'd0, "R6");
        look(20'd2, 8'd1, 1'b1, 20'h01002, 3'd2, "R6");

        // R7: wired slot is oldest but never evicted
        do_flush();
        fill(20'h00040, 8'd3, 20'h04040, 3'd7, 1'b1, 1'b0);
        for (int i = 0; i < 15; i++)
            fill(20'h00050 + 20'(i), 8'd3, 20'h06000 + 20'(i), 3'd1, 1'b0, 1'b0);
        fill(20'h00060, 8'd3, 20'h06060, 3'd6, 1'b0, 1'b0);
        look(20'h00040, 8'd3, 1'b1, 20'h04040, 3'd7, "R7");
        look(20'h00050, 8'd3, 1'b0, 20'h0, 3'd0, "R7");
        look(20'h00060, 8'd3, 1'b1, 20'h06060, 3'd6, "R7");

        // R8: flush keeps wired only
        do_flush();
        look(20'h00040, 8'd3, 1'b1, 20'h04040, 3'd7, "R8");
        look(20'h00051, 8'd3, 1'b0, 20'h0, 3'd0, "R8");
        look(20'h00060, 8'd3, 1'b0, 20'h0, 3'd0, "R8");

        // R12: idle lookup port gives nothing even for a resident page
        @(negedge clk);
        drive_idle();
        lk_vpn = 20'h00040; lk_asid = 8'd3;
        #1;
        checks++;
        if (lk_hit !== 1'b0 || lk_pfn !== 20'h0 || lk_prot !== 3'd0) begin
            errors++;
            $display("FAIL R12: got hit=%b pfn=%h prot=%0d, expected hit=0 pfn=0 prot=0",
                     lk_hit, lk_pfn, lk_prot);
        end

        // R10: flush and fill in one cycle
        fill(20'h00071, 8'd4, 20'h07071, 3'd2, 1'b0, 1'b0);
        fill(20'h00070, 8'd4, 20'h07070, 3'd5, 1'b0, 1'b1);
        look(20'h00071, 8'd4, 1'b0, 20'h0, 3'd0, "R10");
        look(20'h00070, 8'd4, 1'b1, 20'h07070, 3'd5, "R10");

        // R9: all slots wired, a new fill is dropped
        do_flush();
        for (int i = 0; i < 15; i++)
            fill(20'h00080 + 20'(i), 8'd5, 20'h08000 + 20'(i), 3'd3, 1'b1, 1'b0);
        fill(20'h00090, 8'd5, 20'h09090, 3'd1, 1'b0, 1'b0);
        look(20'h00090, 8'd5, 1'b0, 20'h0, 3'd0, "R9");
        look(20'h00040, 8'd3, 1'b1, 20'h04040, 3'd7, "R9");
        look(20'h0008E, 8'd5, 1'b1, 20'h0800E, 3'd3, "R9");

        // R5: overwrite releases the wired flag, then flush removes it
        fill(20'h00040, 8'd3, 20'h04444, 3'd0, 1'b0, 1'b0);
        look(20'h00040, 8'd3, 1'b1, 20'h04444, 3'd0, "R5");
        do_flush();
        look(20'h00040, 8'd3, 1'b0, 20'h0, 3'd0, "R5");
        look(20'h00080, 8'd5, 1'b1, 20'h08000, 3'd3, "R8");

        // R11: reset mid-run empties the buffer
        @(negedge clk);
        drive_idle();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        look(20'h00080, 8'd5, 1'b0, 20'h0, 3'd0, "R11");

        @(negedge clk);
        drive_idle();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule